// File: doc/BRIEF.md
# Double-Buffered Gate Schedule Executor

This block runs a time-aware transmit gate schedule for one Ethernet port. The schedule lives in a command store with two banks. Each command pairs an 8-bit mask of the priority queues allowed to transmit with a duration. The duration counts transmit ticks: bytes on a gigabit link, nibbles on a 10/100 link. A cycle-start pulse from an outside timer restarts the list at command 0 of the active bank. The block then walks the commands in order, and each command's mask stays on the `gate_mask` output until that command's count runs out.

Software loads the bank that is not in use through a plain write port. It then points `bank_sel` at that bank. The block switches banks only when a cycle starts, so a schedule in progress is never changed part way through. Software can tell the switch is done when `active_bank` equals `bank_sel`. A command with a zero count ends the list, and its mask stays in force until the next cycle start, which covers a cycle that runs over. The write port has no back-pressure: a write offered with `wr_en` high is always taken on that clock edge.

Top module: `gate_sched_exec`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at command `wr_addr[5:0]` of bank `wr_addr[6]`. In a command word, bits 21:8 are the count and bits 7:0 are the queue mask, where bit q allows queue q.
- R2: When `cycle_start` is sampled high with gating enabled, `gate_mask` holds its value at the next edge. The mask of command 0 appears one edge after that.
- R3: A command's count is reduced once per `byte_tick` when `speed_gig` is 1, and once per `nibble_tick` when `speed_gig` is 0. The unselected tick line has no effect.
- R4: After the last tick of a nonzero command, the following edge fetches the next command, and that command's mask appears on the edge after the fetch.
- R5: A nonzero count below 16 lasts exactly 16 ticks.
- R6: A command with a zero count ends the list. Its mask stays on `gate_mask` until the next cycle start.
- R7: `active_bank` changes only at a cycle start, taking the value of `bank_sel`, and only when one-bank mode is off and gating is enabled.
- R8: While `one_bank` is high, `active_bank` never changes.
- R9: Unless both `glb_en` and `port_en` are high, `gate_mask` is all ones and both error flags are clear from the next edge on. After reset, and when gating is enabled but no cycle has started yet, `gate_mask` is all ones.
- R10: Fetching a command whose count is nonzero and below 16 sets `err_cnt`. The flag stays set while gating remains enabled.
- R11: If the last tick of command 63 arrives without a zero-count command having ended the list, `err_addr` is set on that edge and command 63's mask stays on. The flag stays set while gating remains enabled.
- R12: A cycle start that arrives while a command is still counting aborts that command and restarts the list from command 0, with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Gating enable shared by all ports |
| port_en | input | 1 | Gating enable for this port |
| one_bank | input | 1 | Single-bank mode: no bank swapping |
| bank_sel | input | 1 | Bank that software wants executed |
| speed_gig | input | 1 | 1: count byte ticks; 0: count nibble ticks |
| byte_tick | input | 1 | One byte transmitted |
| nibble_tick | input | 1 | One nibble transmitted |
| cycle_start | input | 1 | Schedule cycle boundary pulse |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | 7 | Bank (MSB) and command index |
| wr_data | input | 22 | Command word: count 21:8, mask 7:0 |
| gate_mask | output | 8 | Registered per-queue transmit allow |
| active_bank | output | 1 | Bank being executed |
| err_cnt | output | 1 | Short count seen (sticky) |
| err_addr | output | 1 | Ran past end of bank (sticky) |

## Verification
The bench uses the default parameters: 64 commands per bank, a 14-bit count, an 8-bit mask and a minimum duration of 16. With these values a bank filled entirely with minimum-length commands runs off its end in about 1100 cycles, so the address-error path can be reached. Random lists of short commands test the fetch timing, the terminator hold and the bank swap on both tick sources. Large 14-bit counts are not needed to reach any decision point, so they are left out.

// File: rtl/gse_pkg.sv
package gse_pkg;
  localparam int unsigned MASK_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 14;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_COUNT,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/gse_cmd_ram.sv
module gse_cmd_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CMD_W = 22,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IW:0]      wr_addr,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             rd_bank,
  input  logic [IW-1:0]    rd_idx,
  output logic [CMD_W-1:0] rd_data
);
  logic [CMD_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [CMD_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[IW] == 1'(b)))
        mem[wr_addr[IW-1:0]] <= wr_data;
    end
    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/gse_bank_ctl.sv
module gse_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cycle_start,
  input  logic one_bank,
  input  logic bank_sel,
  output logic act_bank
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      act_bank <= 1'b0;
    else if (enable && cycle_start && !one_bank)
      act_bank <= bank_sel;
  end
endmodule

// File: rtl/gse_sequencer.sv
module gse_sequencer
  import gse_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned MASK_W  = 8,
  parameter int unsigned MIN_CNT = 16,
  localparam int unsigned IW    = $clog2(DEPTH),
  localparam int unsigned CMD_W = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cycle_start,
  input  logic              tick,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [IW-1:0]     rd_idx,
  output logic [MASK_W-1:0] gate_mask,
  output logic              err_cnt,
  output logic              err_addr
);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_CNT);
  localparam logic [IW-1:0]    LAST_I = IW'(DEPTH - 1);

  seq_state_e         state;
  logic [CNT_W-1:0]   remain;
  logic [CNT_W-1:0]   cmd_cnt;
  logic [MASK_W-1:0]  cmd_mask;
  logic               cmd_short;

  assign cmd_cnt   = cmd_data[CMD_W-1:MASK_W];
  assign cmd_mask  = cmd_data[MASK_W-1:0];
  assign cmd_short = (cmd_cnt != '0) && (cmd_cnt < MIN_C);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state     <= ST_IDLE;
      rd_idx    <= '0;
      remain    <= '0;
      gate_mask <= '1;
      err_cnt   <= 1'b0;
      err_addr  <= 1'b0;
    end else if (cycle_start) begin
      state  <= ST_FETCH;
      rd_idx <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          gate_mask <= cmd_mask;
          if (cmd_cnt == '0) begin
            state <= ST_HOLD;
          end else begin
            remain <= cmd_short ? MIN_C : cmd_cnt;
            if (cmd_short) err_cnt <= 1'b1;
            state <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (tick) begin
            if (remain == CNT_W'(1)) begin
              if (rd_idx == LAST_I) begin
                err_addr <= 1'b1;
                state    <= ST_HOLD;
              end else begin
                rd_idx <= rd_idx + IW'(1);
                state  <= ST_FETCH;
              end
            end else begin
              remain <= remain - CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gate_sched_exec.sv
module gate_sched_exec #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned CNT_W   = gse_pkg::CNT_W_DEF,
  parameter int unsigned MASK_W  = gse_pkg::MASK_W_DEF,
  parameter int unsigned MIN_CNT = 16,
  localparam int unsigned IW    = $clog2(DEPTH),
  localparam int unsigned CMD_W = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              port_en,
  input  logic              one_bank,
  input  logic              bank_sel,
  input  logic              speed_gig,
  input  logic              byte_tick,
  input  logic              nibble_tick,
  input  logic              cycle_start,
  input  logic              wr_en,
  input  logic [IW:0]       wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  output logic [MASK_W-1:0] gate_mask,
  output logic              active_bank,
  output logic              err_cnt,
  output logic              err_addr
);
  logic             enable;
  logic             tick;
  logic [IW-1:0]    rd_idx;
  logic [CMD_W-1:0] cmd_data;

  assign enable = glb_en & port_en;
  assign tick   = speed_gig ? byte_tick : nibble_tick;

  gse_cmd_ram #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_bank (active_bank),
    .rd_idx  (rd_idx),
    .rd_data (cmd_data)
  );

  gse_bank_ctl u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cycle_start (cycle_start),
    .one_bank    (one_bank),
    .bank_sel    (bank_sel),
    .act_bank    (active_bank)
  );

  gse_sequencer #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .MASK_W(MASK_W), .MIN_CNT(MIN_CNT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cycle_start (cycle_start),
    .tick        (tick),
    .cmd_data    (cmd_data),
    .rd_idx      (rd_idx),
    .gate_mask   (gate_mask),
    .err_cnt     (err_cnt),
    .err_addr    (err_addr)
  );
endmodule

// File: rtl/gse_checker.sv
module gse_checker #(
  parameter int unsigned MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic              port_en,
  input logic              one_bank,
  input logic              cycle_start,
  input logic [MASK_W-1:0] gate_mask,
  input logic              active_bank,
  input logic              err_cnt,
  input logic              err_addr
);
  a_r7_swap_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_bank) |-> ($past(cycle_start) && $past(glb_en && port_en)));

  a_r8_one_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_bank) |-> !$past(one_bank));

  a_r9_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_en && port_en) |=> ((&gate_mask) && !err_cnt && !err_addr));

  a_r10_cnt_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt && glb_en && port_en) |=> err_cnt);

  a_r11_addr_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_addr && glb_en && port_en) |=> err_addr);

  a_r2_start_holds_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && glb_en && port_en) |=> $stable(gate_mask));
endmodule

bind gate_sched_exec gse_checker #(.MASK_W(MASK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en      (glb_en),
  .port_en     (port_en),
  .one_bank    (one_bank),
  .cycle_start (cycle_start),
  .gate_mask   (gate_mask),
  .active_bank (active_bank),
  .err_cnt     (err_cnt),
  .err_addr    (err_addr)
);

// File: tb/tb_gate_sched_exec.sv
module tb_gate_sched_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0, port_en = 1'b0, one_bank = 1'b0, bank_sel = 1'b0;
  logic        speed_gig = 1'b1, byte_tick = 1'b0, nibble_tick = 1'b0;
  logic        cycle_start = 1'b0, wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [21:0] wr_data = '0;
  logic [7:0]  gate_mask;
  logic        active_bank, err_cnt, err_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int unsigned pc_cnt [64];
  logic [7:0]  pc_mask [64];

  always #4 clk = ~clk;

  gate_sched_exec dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .port_en(port_en),
    .one_bank(one_bank), .bank_sel(bank_sel), .speed_gig(speed_gig),
    .byte_tick(byte_tick), .nibble_tick(nibble_tick), .cycle_start(cycle_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_mask(gate_mask), .active_bank(active_bank),
    .err_cnt(err_cnt), .err_addr(err_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int unsigned c);
    return (c < 16) ? 16 : int'(c);
  endfunction

  // mask expected t edges after the edge that sampled cycle_start
  function automatic logic [7:0] exp_mask(input int t);
    int s = 1;
    for (int i = 0; i < 64; i++) begin
      if (pc_cnt[i] == 0 || i == 63) return pc_mask[i];
      if (t < s + eff(pc_cnt[i]) + 1) return pc_mask[i];
      s = s + eff(pc_cnt[i]) + 1;
    end
    return pc_mask[63];
  endfunction

  function automatic logic exp_aerr(input int t);
    int s = 1;
    for (int i = 0; i < 64; i++) begin
      if (pc_cnt[i] == 0) return 1'b0;
      if (i == 63) return (t >= s + eff(pc_cnt[i]));
      s = s + eff(pc_cnt[i]) + 1;
    end
    return 1'b0;
  endfunction

  function automatic int span();
    int s = 1;
    for (int i = 0; i < 64; i++) begin
      if (pc_cnt[i] == 0) return s;
      s = s + eff(pc_cnt[i]) + 1;
    end
    return s;
  endfunction

  task automatic wr_cmd(input int bank, input int idx);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 7'(bank * 64 + idx);
    wr_data = {14'(pc_cnt[idx]), pc_mask[idx]};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_bank(input int bank, input int n, input int lo);
    for (int i = 0; i < 64; i++) pc_cnt[i] = 0;
    for (int i = 0; i < n; i++) begin
      pc_cnt[i]  = lo + ((lo == 16) ? 0 : $urandom % 40);
      pc_mask[i] = 8'($urandom);
      wr_cmd(bank, i);
    end
    if (n < 64) begin
      pc_cnt[n]  = 0;
      pc_mask[n] = 8'($urandom);
      wr_cmd(bank, n);
    end
  endtask

  task automatic set_speed(input bit gig);
    speed_gig   = gig;
    byte_tick   = gig;
    nibble_tick = !gig;
  endtask

  task automatic pulse_start();
    @(negedge clk) cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
  endtask

  task automatic run_sched(input int cycles, input string req, input bit chk_aerr);
    pulse_start();
    for (int t = 1; t <= cycles; t++) begin
      @(negedge clk);
      if (speed_gig) nibble_tick = 1'($urandom);
      else           byte_tick   = 1'($urandom);
      chk(req, gate_mask, exp_mask(t));
      if (chk_aerr) chk("R11", err_addr, exp_aerr(t));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset mask", gate_mask, 8'hff);
    chk("R9 reset bank", active_bank, 0);
    chk("R9 reset errs", {err_cnt, err_addr}, 0);

    glb_en = 1'b1; port_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 idle open", gate_mask, 8'hff);

    // R1 R2 R4 R6: bank 0, byte ticks
    set_speed(1'b1);
    load_bank(0, 4, 16);
    run_sched(span() + 30, "R4 R6 gig", 1'b1);
    chk("R7 bank0", active_bank, 0);

    // R3 R7: bank 1 with nibble ticks, select while running
    load_bank(1, 5, 17);
    bank_sel = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 no early swap", active_bank, 0);
    set_speed(1'b0);
    run_sched(span() + 20, "R3 nibble", 1'b0);
    chk("R7 swapped", active_bank, 1);

    // R3: selected tick stalled, other tick active
    pulse_start();
    @(negedge clk);
    byte_tick = 1'b1; nibble_tick = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R3 stalled tick", gate_mask, pc_mask[0]);
    end
    set_speed(1'b0);

    // R8: one-bank mode ignores bank_sel
    one_bank = 1'b1; bank_sel = 1'b0;
    run_sched(span() + 10, "R8 schedule", 1'b0);
    chk("R8 bank held", active_bank, 1);
    one_bank = 1'b0;

    // R5 R10: short count behaves as 16 and raises err_cnt
    set_speed(1'b1);
    load_bank(0, 3, 20);
    chk("R10 clear before", err_cnt, 0);
    pc_cnt[1] = 5;
    wr_cmd(0, 1);
    run_sched(span() + 20, "R5 min count", 1'b0);
    chk("R10 err_cnt", err_cnt, 1);
    chk("R7 back to 0", active_bank, 0);

    // R12: restart mid-command
    pulse_start();
    repeat (9) @(negedge clk);
    run_sched(span() + 10, "R12 abort", 1'b0);

    // R11: full bank of minimum-length commands
    bank_sel = 1'b1;
    load_bank(1, 64, 16);
    run_sched(span() + 20, "R11 full bank", 1'b1);
    chk("R11 err_addr", err_addr, 1);
    chk("R11 last mask", gate_mask, pc_mask[63]);

    // R9: disabling opens all queues and clears flags
    port_en = 1'b0;
    @(negedge clk);
    chk("R9 disabled mask", gate_mask, 8'hff);
    chk("R9 disabled errs", {err_cnt, err_addr}, 0);
    port_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 re-enabled idle", gate_mask, 8'hff);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule